// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Chain with Access Freeze

This block keeps wall-clock time and calendar date for a real-time clock as packed BCD: seconds, minutes, hours, day of month and month. Each counter carries into the next in that order. A prescaler divides an oscillator-rate enable down to one tick per second. A two-bit rate select sets the divisor for one of four crystal frequencies. Hours run either 00 to 23, or 12, 01 to 11 with an afternoon flag.

While a processor access is in progress, the host raises the freeze input. The visible counters then hold still, so a multi-byte read is coherent and software never needs a rollover check. A second that elapses during the freeze is remembered and applied once, in the first cycle after release. A preset write loads one counter and restarts the prescaler, so the next second begins a full period later. Leap years are not tracked: February always ends on the 28th.

Top module: `rtc_time_chain`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hour 00, day 01, month 01, and the afternoon flag is 0.
- R2: A write with `wr_sel_i` equal to 0 (seconds), 1 (minutes), 2 (hour), 3 (day) or 4 (month) loads `wr_data_i` into that counter, and the value is visible after the next clock edge. For the hour, bits 5:0 give the BCD hour and bit 7 gives the afternoon flag.
- R3: With `osc_tick_i` held high, one second elapses every N cycles. N is 32·L for rate 0, 64·L for rate 1, 128·L for rate 2 and L for rate 3, where L is the `LOW_DIV` parameter (32768 by default).
- R4: Any counter write clears the prescaler, so the next second elapses exactly N oscillator enables after the write.
- R5: Seconds and minutes each step 59 to 00. The wrap carries one into the next counter in the same cycle.
- R6: In 24-hour mode the hour steps 23 to 00 and carries into the day.
- R7: In 12-hour mode the hour runs 12, 01 … 11. The afternoon flag toggles on the step from 11 to 12, and the day advances only when 11 PM becomes 12 AM.
- R8: The day counter wraps to 01 after 28 in month 02, after 30 in months 04, 06, 09 and 11, and after 31 in all other months. The wrap advances the month.
- R9: The month steps 12 to 01.
- R10: While `freeze_i` is high, no output changes except through a write.
- R11: A second that elapses during a freeze is applied exactly once, at the first clock edge after `freeze_i` falls. Any further elapsed seconds during the same freeze are merged into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One pulse per oscillator period |
| rate_sel_i | input | 2 | Oscillator rate: 0 = 1.048576 MHz, 1 = 2.097152 MHz, 2 = 4.194304 MHz, 3 = 32.768 kHz |
| hour12_i | input | 1 | 1 selects 12-hour counting |
| freeze_i | input | 1 | Processor access in progress |
| wr_en_i | input | 1 | Counter preset strobe |
| wr_sel_i | input | 3 | Counter to preset |
| wr_data_i | input | 8 | Preset value, packed BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD |
| pm_o | output | 1 | Afternoon flag |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |

## Verification
A write shows on the outputs one edge after the strobe. A second tick shows on the edge where the prescaler reaches its last count. That is the Nth enabled edge after a write, because the write leaves the prescaler at zero. All carries ripple within that same edge. A tick held back by a freeze shows on the first edge after release. The bench drives and samples on falling edges. It holds `osc_tick_i` low during presets and then opens it for a counted number of edges. It checks both one edge before and exactly at the expected edge, so an early or late update is caught.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4
  } cnt_sel_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon);
    case (mon)
      8'h02:                      last_day = 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned LOW_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic [1:0] rate_sel_i,
  input  logic       clr_i,
  output logic       tick_o
);
  localparam int unsigned MAX_DIV = LOW_DIV * 128;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);
  localparam logic [CNT_W-1:0] LAST_R0 = CNT_W'(LOW_DIV * 32 - 1);
  localparam logic [CNT_W-1:0] LAST_R1 = CNT_W'(LOW_DIV * 64 - 1);
  localparam logic [CNT_W-1:0] LAST_R2 = CNT_W'(LOW_DIV * 128 - 1);
  localparam logic [CNT_W-1:0] LAST_R3 = CNT_W'(LOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q, last;

  always_comb begin
    case (rate_sel_i)
      2'd0:    last = LAST_R0;
      2'd1:    last = LAST_R1;
      2'd2:    last = LAST_R2;
      default: last = LAST_R3;
    endcase
  end

  // >= keeps the divider bounded if the rate changes mid-period
  assign tick_o = osc_tick_i && !clr_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (osc_tick_i) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_freeze_ctl.sv
module rtc_freeze_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic freeze_i,
  input  logic wr_i,
  output logic adv_o
);
  logic pend_q;

  assign adv_o = !freeze_i && !wr_i && (tick_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (wr_i)     pend_q <= 1'b0;
    else if (freeze_i) pend_q <= pend_q | tick_i;
    else               pend_q <= pend_q & tick_i; // one consumed, a coincident tick stays
  end
endmodule

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic [7:0] first_i,
  input  logic [7:0] last_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  import rtc_pkg::*;

  logic [7:0] val_q;
  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (ld_i)   val_q <= ld_val_i;
    else if (wrap_o) val_q <= first_i;
    else if (inc_i)  val_q <= bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       hour12_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] hour_o,
  output logic       pm_o,
  output logic       carry_o
);
  import rtc_pkg::*;

  logic [7:0] hour_q;
  logic       pm_q;

  assign hour_o  = hour_q;
  assign pm_o    = pm_q;
  assign carry_o = inc_i && (hour12_i ? (hour_q == 8'h11 && pm_q) : (hour_q >= 8'h23));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hour_q <= 8'h00;
      pm_q   <= 1'b0;
    end else if (ld_i) begin
      hour_q <= {2'b00, ld_val_i[5:0]};
      pm_q   <= ld_val_i[7];
    end else if (inc_i) begin
      if (hour12_i) begin
        if (hour_q == 8'h11) begin
          hour_q <= 8'h12;
          pm_q   <= !pm_q;
        end else if (hour_q >= 8'h12) begin
          hour_q <= 8'h01;
        end else begin
          hour_q <= bcd_inc(hour_q);
        end
      end else begin
        hour_q <= (hour_q >= 8'h23) ? 8'h00 : bcd_inc(hour_q);
      end
    end
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain #(
  parameter int unsigned LOW_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic [1:0] rate_sel_i,
  input  logic       hour12_i,
  input  logic       freeze_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       pm_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o
);
  import rtc_pkg::*;

  logic tick, adv;
  logic sec_wrap, min_wrap, hour_carry, day_wrap, mon_wrap;
  logic [7:0] day_last;

  rtc_prescaler #(.LOW_DIV(LOW_DIV)) u_pre (
    .clk_i, .rst_ni, .osc_tick_i, .rate_sel_i,
    .clr_i (wr_en_i),
    .tick_o(tick)
  );

  rtc_freeze_ctl u_frz (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .freeze_i,
    .wr_i    (wr_en_i),
    .adv_o   (adv)
  );

  rtc_bcd_cnt #(.RST_VAL(8'h00)) u_sec (
    .clk_i, .rst_ni,
    .inc_i   (adv),
    .ld_i    (wr_en_i && wr_sel_i == SEL_SEC),
    .ld_val_i(wr_data_i),
    .first_i (8'h00),
    .last_i  (8'h59),
    .val_o   (sec_o),
    .wrap_o  (sec_wrap)
  );

  rtc_bcd_cnt #(.RST_VAL(8'h00)) u_min (
    .clk_i, .rst_ni,
    .inc_i   (sec_wrap),
    .ld_i    (wr_en_i && wr_sel_i == SEL_MIN),
    .ld_val_i(wr_data_i),
    .first_i (8'h00),
    .last_i  (8'h59),
    .val_o   (min_o),
    .wrap_o  (min_wrap)
  );

  rtc_hour_cnt u_hour (
    .clk_i, .rst_ni,
    .inc_i   (min_wrap),
    .hour12_i,
    .ld_i    (wr_en_i && wr_sel_i == SEL_HOUR),
    .ld_val_i(wr_data_i),
    .hour_o,
    .pm_o,
    .carry_o (hour_carry)
  );

  assign day_last = last_day(mon_o);

  rtc_bcd_cnt #(.RST_VAL(8'h01)) u_day (
    .clk_i, .rst_ni,
    .inc_i   (hour_carry),
    .ld_i    (wr_en_i && wr_sel_i == SEL_DAY),
    .ld_val_i(wr_data_i),
    .first_i (8'h01),
    .last_i  (day_last),
    .val_o   (day_o),
    .wrap_o  (day_wrap)
  );

  rtc_bcd_cnt #(.RST_VAL(8'h01)) u_mon (
    .clk_i, .rst_ni,
    .inc_i   (day_wrap),
    .ld_i    (wr_en_i && wr_sel_i == SEL_MON),
    .ld_val_i(wr_data_i),
    .first_i (8'h01),
    .last_i  (8'h12),
    .val_o   (mon_o),
    .wrap_o  (mon_wrap)
  );

  logic unused_ok;
  assign unused_ok = mon_wrap;
endmodule

// File: rtl/rtc_time_chain_chk.sv
module rtc_time_chain_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_tick_i,
  input logic [1:0] rate_sel_i,
  input logic       hour12_i,
  input logic       freeze_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic       pm_o,
  input logic [7:0] day_o,
  input logic [7:0] mon_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R10
  frozen_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(freeze_i) && !$past(wr_en_i) |->
      $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(pm_o) && $stable(day_o) && $stable(mon_o));

  // R2
  sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(wr_en_i) && $past(wr_sel_i) == 3'd0 |-> sec_o == $past(wr_data_i));

  // R2
  mon_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(wr_en_i) && $past(wr_sel_i) == 3'd4 |-> mon_o == $past(wr_data_i));

  // R5
  min_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(wr_en_i) && min_o != $past(min_o) |-> $past(sec_o) == 8'h59);

  // R7
  pm_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(wr_en_i) && pm_o != $past(pm_o) |-> $past(hour_o) == 8'h11);

  // R8
  mon_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(wr_en_i) && mon_o != $past(mon_o) |-> $past(day_o) >= 8'h28);
endmodule

bind rtc_time_chain rtc_time_chain_chk u_chk (.*);

// File: tb/tb_rtc_time_chain.sv
module tb_rtc_time_chain;
  localparam int unsigned LOW_DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic [1:0] rate_sel_i = 2'd3;
  logic       hour12_i = 1'b0;
  logic       freeze_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o;
  logic       pm_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  rtc_time_chain #(.LOW_DIV(LOW_DIV)) dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] sel, input logic [7:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] d, input logic [7:0] mo);
    put(3'd4, mo); put(3'd3, d); put(3'd2, h); put(3'd1, m); put(3'd0, s);
  endtask

  task automatic run(input int n);
    osc_tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    osc_tick_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sec", sec_o, 8'h00); chk("R1 min", min_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00); chk("R1 pm", {7'd0, pm_o}, 8'h00);
    chk("R1 day", day_o, 8'h01); chk("R1 mon", mon_o, 8'h01);
  endtask

  task automatic t_write;
    set_all(8'h08, 8'h15, 8'h42, 8'h17, 8'h06);
    chk("R2 sec", sec_o, 8'h42); chk("R2 min", min_o, 8'h15);
    chk("R2 hour", hour_o, 8'h08); chk("R2 day", day_o, 8'h17);
    chk("R2 mon", mon_o, 8'h06);
    put(3'd2, 8'h87);
    chk("R2 hour pm", hour_o, 8'h07); chk("R2 pm", {7'd0, pm_o}, 8'h01);
  endtask

  task automatic t_rate;
    for (int r = 0; r < 4; r++) begin
      int n;
      n = (r == 0) ? LOW_DIV * 32 : (r == 1) ? LOW_DIV * 64 : (r == 2) ? LOW_DIV * 128 : LOW_DIV;
      rate_sel_i = 2'(r);
      put(3'd0, 8'h10);
      run(n - 1);
      chk("R3 before period", sec_o, 8'h10);
      run(1);
      chk("R3 at period", sec_o, 8'h11);
    end
    rate_sel_i = 2'd3;
  endtask

  task automatic t_clear;
    put(3'd0, 8'h20);
    run(2);
    put(3'd0, 8'h40);
    run(LOW_DIV - 1);
    chk("R4 no early tick", sec_o, 8'h40);
    run(1);
    chk("R4 full period", sec_o, 8'h41);
  endtask

  task automatic t_carry;
    hour12_i = 1'b0;
    set_all(8'h10, 8'h59, 8'h58, 8'h05, 8'h03);
    run(LOW_DIV);
    chk("R5 sec 59", sec_o, 8'h59); chk("R5 min hold", min_o, 8'h59);
    run(LOW_DIV);
    chk("R5 sec wrap", sec_o, 8'h00); chk("R5 min wrap", min_o, 8'h00);
    chk("R5 hour carry", hour_o, 8'h11);
  endtask

  task automatic t_24h;
    set_all(8'h23, 8'h59, 8'h59, 8'h14, 8'h05);
    run(LOW_DIV);
    chk("R6 hour wrap", hour_o, 8'h00); chk("R6 day carry", day_o, 8'h15);
    chk("R6 min", min_o, 8'h00);
  endtask

  task automatic t_12h;
    hour12_i = 1'b1;
    set_all(8'h11, 8'h59, 8'h59, 8'h09, 8'h07);
    run(LOW_DIV);
    chk("R7 11->12", hour_o, 8'h12); chk("R7 to pm", {7'd0, pm_o}, 8'h01);
    chk("R7 noon keeps day", day_o, 8'h09);
    put(3'd1, 8'h59); put(3'd0, 8'h59);
    run(LOW_DIV);
    chk("R7 12->01", hour_o, 8'h01); chk("R7 pm held", {7'd0, pm_o}, 8'h01);
    put(3'd2, 8'h91); put(3'd1, 8'h59); put(3'd0, 8'h59);
    run(LOW_DIV);
    chk("R7 midnight hour", hour_o, 8'h12); chk("R7 to am", {7'd0, pm_o}, 8'h00);
    chk("R7 midnight day", day_o, 8'h10);
    hour12_i = 1'b0;
  endtask

  task automatic month_end(input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] ed, input logic [7:0] emo, input string req);
    set_all(8'h23, 8'h59, 8'h59, d, mo);
    run(LOW_DIV);
    chk({req, " day"}, day_o, ed);
    chk({req, " mon"}, mon_o, emo);
  endtask

  task automatic t_month;
    month_end(8'h28, 8'h02, 8'h01, 8'h03, "R8 feb");
    month_end(8'h30, 8'h04, 8'h01, 8'h05, "R8 apr");
    month_end(8'h30, 8'h11, 8'h01, 8'h12, "R8 nov");
    month_end(8'h30, 8'h01, 8'h31, 8'h01, "R8 jan30");
    month_end(8'h31, 8'h08, 8'h01, 8'h09, "R8 aug");
    month_end(8'h31, 8'h12, 8'h01, 8'h01, "R9 dec");
  endtask

  task automatic t_freeze;
    set_all(8'h10, 8'h20, 8'h30, 8'h02, 8'h02);
    freeze_i = 1'b1;
    run(LOW_DIV);
    chk("R10 frozen sec", sec_o, 8'h30);
    run(LOW_DIV);
    chk("R10 frozen sec 2", sec_o, 8'h30); chk("R10 frozen min", min_o, 8'h20);
    freeze_i = 1'b0;
    @(negedge clk_i);
    chk("R11 replay", sec_o, 8'h31);
    repeat (3) @(negedge clk_i);
    chk("R11 once", sec_o, 8'h31);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_write;
    t_rate;
    t_clear;
    t_carry;
    t_24h;
    t_12h;
    t_month;
    t_freeze;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule